// File: doc/BRIEF.md
# Event Readout Word Formatter

The formatter takes one captured detector event at a time and turns it into a series of 32-bit readout words. These words are pushed into a 64-entry readout FIFO. An event carries several things: a 13-bit hit pattern, then for each of five germanium channels (A to D and a spare) a high-gain energy, a low-gain energy, a trigger-time TAC value and a crossover TAC value, together with that channel's pre-pulse and post-pulse pileup flags, and finally a shield energy, a shield TAC value and a card-level anti-Compton veto flag. Every word carries a 2-bit qualifier, the item number and a host-supplied group number above its 16-bit data field. The qualifier is derived from the flags, and the rule used depends on which kind of item the word holds.

A host-supplied mask selects which items are emitted. The enabled items of an event go out in ascending item order, one item slot per clock. A 4-bit control write selects mark or reject mode and can empty the FIFO. In reject mode an event that carries a veto or any pre-pulse pileup is dropped on entry. For test purposes, a host word can be pushed straight into the FIFO and the FIFO head can be popped. Downstream logic drains the FIFO through a valid/ready pair.

Top module: `rdo_word_formatter`

## Requirements
- R1: Each word has bits 31:30 = qualifier, bits 29:24 = item number, bits 23:16 = `grp_id` sampled in the cycle the word is pushed.
- R2: Item numbering is as follows: item 0 is the pattern; germanium channel c (0..4 = A, B, C, D, spare) with kind t (0 high-gain energy, 1 low-gain energy, 2 trigger TAC, 3 crossover TAC) is item 1+4c+t; item 21 is the shield energy and item 22 the shield TAC. In value words, bits 12:0 hold the 13-bit value and bits 15:13 are zero.
- R3: The pattern word (item 0) carries `evt_pattern` in bits 12:0, bits 15:13 zero, and qualifier 00. Within the pattern, shield pairs 1..8 sit in bits 7:0, germanium A..D in bits 11:8 and the spare in bit 12.
- R4: The qualifier of both germanium energy words is {channel pre-pileup OR post-pileup, veto}: 00 clean, 01 veto only, 10 pileup only, 11 both.
- R5: The qualifier of the crossover TAC word is {channel pre-pileup, channel post-pileup}. The trigger TAC word always has qualifier 00.
- R6: Both shield words always carry qualifier 11.
- R7: An event is accepted when `evt_valid` is high while `evt_ready` is high. The item slot for item i then falls on clock edge a+1+i, where a is the accepting edge, and the word for item i is pushed on that edge only when `item_mask[i]` is 1. `evt_ready` stays low from the accepting edge through the edge of item 22. Each stall cycle delays every remaining slot by one.
- R8: Control bit 1 selects the mode (1 = mark, 0 = reject), and reset selects reject. In reject mode an event with `evt_veto` set or any `evt_pre` bit set produces no words and leaves `evt_ready` high. In mark mode such events are emitted. An event with only post-pulse pileup is emitted in both modes.
- R9: The FIFO holds 64 words. `out_valid` is high exactly when it is non-empty, `out_data` is the oldest word, and a word is removed on each edge where `out_valid` and `out_ready` are both high. The FIFO is empty after reset.
- R10: A push into a full FIFO with no pop on the same edge loses the word and sets `err_flag`. The flag stays set until a FIFO clear.
- R11: A control write with bit 3 set empties the FIFO and clears `err_flag` on that edge, overriding any push or pop on the same edge. The bit does not stay set.
- R12: `tst_wr` pushes `tst_wdata` on that edge and stalls the item sequence for that cycle. `tst_rd` removes the head word when the FIFO is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 4 | Control data: bit 3 FIFO clear, bit 1 mark mode |
| grp_id | input | 8 | Group number placed in bits 23:16 |
| item_mask | input | 23 | Per-item emit enable |
| evt_valid | input | 1 | Event present |
| evt_ready | output | 1 | Formatter idle, event can be taken |
| evt_pattern | input | 13 | Hit pattern |
| evt_ehi | input | 65 | High-gain energies, channel c at bits 13c+12:13c |
| evt_elo | input | 65 | Low-gain energies, same packing |
| evt_ttrig | input | 65 | Trigger TAC values, same packing |
| evt_txo | input | 65 | Crossover TAC values, same packing |
| evt_pre | input | 5 | Pre-pulse pileup per channel |
| evt_post | input | 5 | Post-pulse pileup per channel |
| evt_veto | input | 1 | Anti-Compton veto |
| evt_sh_e | input | 13 | Shield energy |
| evt_sh_t | input | 13 | Shield TAC value |
| tst_wr | input | 1 | Test push strobe |
| tst_wdata | input | 32 | Test push word |
| tst_rd | input | 1 | Test pop strobe |
| out_valid | output | 1 | FIFO non-empty |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | 32 | FIFO head word |
| err_flag | output | 1 | Sticky overflow indicator |

## Verification
The FIFO head is read combinationally. A word pushed on edge a+1+i into an empty FIFO therefore appears on `out_data` right after that edge, and a pop, a clear or a change of the mode bit takes effect on the edge that samples it. A behavioural reference model keeps a queue of expected words, the busy state and the sticky flag. It updates on the same edges the design registers on. Every output is compared 5 ns after each rising edge, by which time all registered results have settled. Directed checks for rejection, clearing and test access sample at the falling edge that follows the edge of the stimulus.

// File: rtl/rdo_pkg.sv
`timescale 1ns/1ps
package rdo_pkg;
  localparam int QUAL_W       = 2;
  localparam int ITEM_W       = 6;
  localparam int GROUP_W      = 8;
  localparam int HALF_W       = 16;
  localparam int WORD_W       = QUAL_W + ITEM_W + GROUP_W + HALF_W;
  localparam int KINDS_PER_GE = 4;
  localparam int SHIELD_ITEMS = 2;

  typedef enum logic [2:0] {
    K_PATTERN,
    K_GE_EHI,
    K_GE_ELO,
    K_TAC_TRIG,
    K_TAC_XO,
    K_SH_E,
    K_SH_T
  } kind_t;

  typedef logic [QUAL_W-1:0] qual_t;
endpackage

// File: rtl/rdo_qual.sv
`timescale 1ns/1ps
module rdo_qual
  import rdo_pkg::*;
(
  input  kind_t kind,
  input  logic  pre_pu,
  input  logic  post_pu,
  input  logic  veto,
  output qual_t qual
);
  always_comb begin
    unique case (kind)
      K_GE_EHI, K_GE_ELO: qual = {pre_pu | post_pu, veto};
      K_TAC_XO:           qual = {pre_pu, post_pu};
      K_SH_E, K_SH_T:     qual = 2'b11;
      default:            qual = 2'b00;
    endcase
  end
endmodule

// File: rtl/rdo_seq.sv
`timescale 1ns/1ps
module rdo_seq
  import rdo_pkg::*;
#(
  parameter int GE_CH = 5,
  parameter int VAL_W = 13,
  localparam int PAT_W     = 8 + GE_CH,
  localparam int VEC_W     = GE_CH * VAL_W,
  localparam int NUM_ITEMS = 1 + KINDS_PER_GE * GE_CH + SHIELD_ITEMS,
  localparam int CNT_W     = $clog2(NUM_ITEMS)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mark_mode,
  input  logic                 stall,
  input  logic                 evt_valid,
  input  logic [PAT_W-1:0]     evt_pattern,
  input  logic [VEC_W-1:0]     evt_ehi,
  input  logic [VEC_W-1:0]     evt_elo,
  input  logic [VEC_W-1:0]     evt_ttrig,
  input  logic [VEC_W-1:0]     evt_txo,
  input  logic [GE_CH-1:0]     evt_pre,
  input  logic [GE_CH-1:0]     evt_post,
  input  logic                 evt_veto,
  input  logic [VAL_W-1:0]     evt_sh_e,
  input  logic [VAL_W-1:0]     evt_sh_t,
  input  logic [NUM_ITEMS-1:0] item_mask,
  output logic                 evt_ready,
  output logic                 emit_valid,
  output logic [ITEM_W-1:0]    emit_item,
  output kind_t                emit_kind,
  output logic [HALF_W-1:0]    emit_data,
  output logic                 emit_pre,
  output logic                 emit_post,
  output logic                 emit_veto
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_ITEMS - 1);
  localparam logic [CNT_W-1:0] GE_LAST  = CNT_W'(KINDS_PER_GE * GE_CH);
  localparam logic [CNT_W-1:0] SH_E_IDX = CNT_W'(KINDS_PER_GE * GE_CH + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cur_q, cur_d;
  logic             accept, reject, start;

  logic [PAT_W-1:0] pat_q;
  logic [VEC_W-1:0] ehi_q, elo_q, ttrig_q, txo_q;
  logic [GE_CH-1:0] pre_q, post_q;
  logic             veto_q;
  logic [VAL_W-1:0] sh_e_q, sh_t_q;

  // Entry decision and item walk.
  always_comb begin
    accept = evt_valid && !busy_q;
    reject = !mark_mode && (evt_veto || (|evt_pre));
    start  = accept && !reject;
    busy_d = busy_q;
    cur_d  = cur_q;
    if (busy_q) begin
      if (!stall) begin
        if (cur_q == LAST_IDX) busy_d = 1'b0;
        else                   cur_d  = cur_q + CNT_W'(1);
      end
    end else if (start) begin
      busy_d = 1'b1;
      cur_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
    end
  end

  // Event capture, datapath only, loaded with a clock enable.
  always_ff @(posedge clk) begin
    if (start) begin
      pat_q   <= evt_pattern;
      ehi_q   <= evt_ehi;
      elo_q   <= evt_elo;
      ttrig_q <= evt_ttrig;
      txo_q   <= evt_txo;
      pre_q   <= evt_pre;
      post_q  <= evt_post;
      veto_q  <= evt_veto;
      sh_e_q  <= evt_sh_e;
      sh_t_q  <= evt_sh_t;
    end
  end

  // Item decode for the current slot.
  logic [CNT_W-1:0] idx;
  logic [CNT_W-3:0] ch;
  logic [1:0]       sub;

  always_comb begin
    idx       = cur_q - CNT_W'(1);
    ch        = idx[CNT_W-1:2];
    sub       = idx[1:0];
    emit_kind = K_PATTERN;
    emit_data = HALF_W'(pat_q);
    emit_pre  = 1'b0;
    emit_post = 1'b0;
    if (cur_q != '0 && cur_q <= GE_LAST) begin
      emit_pre  = pre_q[ch];
      emit_post = post_q[ch];
      unique case (sub)
        2'd0: begin emit_kind = K_GE_EHI;   emit_data = HALF_W'(ehi_q[int'(ch)*VAL_W +: VAL_W]);   end
        2'd1: begin emit_kind = K_GE_ELO;   emit_data = HALF_W'(elo_q[int'(ch)*VAL_W +: VAL_W]);   end
        2'd2: begin emit_kind = K_TAC_TRIG; emit_data = HALF_W'(ttrig_q[int'(ch)*VAL_W +: VAL_W]); end
        default: begin emit_kind = K_TAC_XO; emit_data = HALF_W'(txo_q[int'(ch)*VAL_W +: VAL_W]);  end
      endcase
    end else if (cur_q == SH_E_IDX) begin
      emit_kind = K_SH_E;
      emit_data = HALF_W'(sh_e_q);
    end else if (cur_q > SH_E_IDX) begin
      emit_kind = K_SH_T;
      emit_data = HALF_W'(sh_t_q);
    end
  end

  assign emit_veto  = veto_q;
  assign emit_item  = ITEM_W'(cur_q);
  assign emit_valid = busy_q && !stall && item_mask[cur_q];
  assign evt_ready  = !busy_q;

  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !busy_q && !mark_mode && (evt_veto || (|evt_pre))) |=> !busy_q); // R8
  AST_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cur_q) == LAST_IDX)); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && stall) |=> (busy_q && $stable(cur_q))); // R12
endmodule

// File: rtl/rdo_fifo.sv
`timescale 1ns/1ps
module rdo_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         err
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          pop_ok, push_ok, ovf;

  always_comb begin
    pop_ok  = pop && (cnt_q != '0);
    push_ok = push && ((cnt_q != FULL_CNT) || pop_ok);
    ovf     = push && !push_ok;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    err_d   = err_q | ovf;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
      err_d = 1'b0;
    end else begin
      if (push_ok) wr_d = wr_q + AW'(1);
      if (pop_ok)  rd_d = rd_q + AW'(1);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + (AW+1)'(1);
        2'b01:   cnt_d = cnt_q - (AW+1)'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_q] <= push_data;
  end

  assign head      = mem[rd_q];
  assign not_empty = (cnt_q != '0);
  assign err       = err_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr) |=> err_q); // R10
  AST_OVF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && (cnt_q == FULL_CNT) && !clr) |=> err_q); // R10
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!not_empty && !err_q)); // R11
endmodule

// File: rtl/rdo_word_formatter.sv
`timescale 1ns/1ps
module rdo_word_formatter
  import rdo_pkg::*;
#(
  parameter int GE_CH      = 5,
  parameter int VAL_W      = 13,
  parameter int FIFO_DEPTH = 64,
  localparam int PAT_W     = 8 + GE_CH,
  localparam int VEC_W     = GE_CH * VAL_W,
  localparam int NUM_ITEMS = 1 + KINDS_PER_GE * GE_CH + SHIELD_ITEMS
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_we,
  input  logic [3:0]           ctrl_wdata,
  input  logic [GROUP_W-1:0]   grp_id,
  input  logic [NUM_ITEMS-1:0] item_mask,
  input  logic                 evt_valid,
  output logic                 evt_ready,
  input  logic [PAT_W-1:0]     evt_pattern,
  input  logic [VEC_W-1:0]     evt_ehi,
  input  logic [VEC_W-1:0]     evt_elo,
  input  logic [VEC_W-1:0]     evt_ttrig,
  input  logic [VEC_W-1:0]     evt_txo,
  input  logic [GE_CH-1:0]     evt_pre,
  input  logic [GE_CH-1:0]     evt_post,
  input  logic                 evt_veto,
  input  logic [VAL_W-1:0]     evt_sh_e,
  input  logic [VAL_W-1:0]     evt_sh_t,
  input  logic                 tst_wr,
  input  logic [WORD_W-1:0]    tst_wdata,
  input  logic                 tst_rd,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORD_W-1:0]    out_data,
  output logic                 err_flag
);
  localparam int CLR_BIT  = 3;
  localparam int MARK_BIT = 1;

  logic mark_q, mark_d;
  logic fifo_clr;
  logic unused_ctrl;

  assign unused_ctrl = ^{ctrl_wdata[0], ctrl_wdata[2]};

  always_comb begin
    mark_d   = ctrl_we ? ctrl_wdata[MARK_BIT] : mark_q;
    fifo_clr = ctrl_we && ctrl_wdata[CLR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mark_q <= 1'b0;
    else        mark_q <= mark_d;
  end

  logic              emit_valid;
  logic [ITEM_W-1:0] emit_item;
  kind_t             emit_kind;
  logic [HALF_W-1:0] emit_data;
  logic              emit_pre, emit_post, emit_veto;
  qual_t             emit_qual;

  rdo_seq #(.GE_CH(GE_CH), .VAL_W(VAL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mark_mode  (mark_q),
    .stall      (tst_wr),
    .evt_valid  (evt_valid),
    .evt_pattern(evt_pattern),
    .evt_ehi    (evt_ehi),
    .evt_elo    (evt_elo),
    .evt_ttrig  (evt_ttrig),
    .evt_txo    (evt_txo),
    .evt_pre    (evt_pre),
    .evt_post   (evt_post),
    .evt_veto   (evt_veto),
    .evt_sh_e   (evt_sh_e),
    .evt_sh_t   (evt_sh_t),
    .item_mask  (item_mask),
    .evt_ready  (evt_ready),
    .emit_valid (emit_valid),
    .emit_item  (emit_item),
    .emit_kind  (emit_kind),
    .emit_data  (emit_data),
    .emit_pre   (emit_pre),
    .emit_post  (emit_post),
    .emit_veto  (emit_veto)
  );

  rdo_qual u_qual (
    .kind   (emit_kind),
    .pre_pu (emit_pre),
    .post_pu(emit_post),
    .veto   (emit_veto),
    .qual   (emit_qual)
  );

  logic [WORD_W-1:0] seq_word, push_word;
  logic              push;

  always_comb begin
    seq_word  = {emit_qual, emit_item, grp_id, emit_data};
    push      = tst_wr || emit_valid;
    push_word = tst_wr ? tst_wdata : seq_word;
  end

  rdo_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (fifo_clr),
    .push     (push),
    .push_data(push_word),
    .pop      (tst_rd || out_ready),
    .head     (out_data),
    .not_empty(out_valid),
    .err      (err_flag)
  );

  AST_SHIELD_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_valid && (emit_kind == K_SH_E || emit_kind == K_SH_T)) |-> (seq_word[31:30] == 2'b11)); // R6
  AST_TRIG_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_valid && emit_kind == K_TAC_TRIG) |-> (seq_word[31:30] == 2'b00)); // R5
  AST_TEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tst_wr |-> !emit_valid); // R12
endmodule

// File: tb/test_rdo_word_formatter.sv
`timescale 1ns/1ps
module test_rdo_word_formatter;
  localparam int GE = 5;
  localparam int VW = 13;
  localparam int NI = 23;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic ctrl_we;
  logic [3:0] ctrl_wdata;
  logic [7:0] grp_id;
  logic [NI-1:0] item_mask;
  logic evt_valid, evt_ready;
  logic [12:0] evt_pattern;
  logic [GE*VW-1:0] evt_ehi, evt_elo, evt_ttrig, evt_txo;
  logic [GE-1:0] evt_pre, evt_post;
  logic evt_veto;
  logic [VW-1:0] evt_sh_e, evt_sh_t;
  logic tst_wr, tst_rd, out_valid, out_ready, err_flag;
  logic [31:0] tst_wdata, out_data;

  always #10 clk = ~clk;

  rdo_word_formatter i_rdo_word_formatter (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .grp_id(grp_id), .item_mask(item_mask), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_pattern(evt_pattern), .evt_ehi(evt_ehi),
    .evt_elo(evt_elo), .evt_ttrig(evt_ttrig), .evt_txo(evt_txo),
    .evt_pre(evt_pre), .evt_post(evt_post), .evt_veto(evt_veto),
    .evt_sh_e(evt_sh_e), .evt_sh_t(evt_sh_t), .tst_wr(tst_wr),
    .tst_wdata(tst_wdata), .tst_rd(tst_rd), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .err_flag(err_flag)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit run_chk = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model state
  logic [31:0] mq[$];
  bit m_busy, m_mark, m_err;
  int m_cur;
  logic [12:0] m_pat;
  logic [VW-1:0] m_ehi[GE], m_elo[GE], m_trig[GE], m_xo[GE];
  logic [GE-1:0] m_pre, m_post;
  logic m_veto;
  logic [VW-1:0] m_she, m_sht;

  function automatic logic [31:0] mk_word(int it);
    logic [1:0] q;
    logic [15:0] d;
    int c, t;
    q = 2'b00;
    d = 16'h0;
    if (it == 0) d = {3'b000, m_pat};
    else if (it <= 4*GE) begin
      c = (it-1) / 4;
      t = (it-1) % 4;
      case (t)
        0: begin d = {3'b000, m_ehi[c]}; q = {m_pre[c] | m_post[c], m_veto}; end
        1: begin d = {3'b000, m_elo[c]}; q = {m_pre[c] | m_post[c], m_veto}; end
        2: begin d = {3'b000, m_trig[c]}; q = 2'b00; end
        default: begin d = {3'b000, m_xo[c]}; q = {m_pre[c], m_post[c]}; end
      endcase
    end else if (it == 4*GE+1) begin d = {3'b000, m_she}; q = 2'b11; end
    else begin d = {3'b000, m_sht}; q = 2'b11; end
    return {q, 6'(it), grp_id, d};
  endfunction

  function automatic string tag_of(logic [31:0] a, logic [31:0] e);
    int it;
    it = int'(e[29:24]);
    if (a[29:16] != e[29:16]) return "R1";
    if (a[15:0] != e[15:0]) return (it == 0) ? "R3" : "R2";
    if (it == 0) return "R3";
    if (it > 4*GE) return "R6";
    if (((it-1) % 4) < 2) return "R4";
    return "R5";
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit pop, has;
    logic [31:0] w;
    if (!rst_n) begin
      mq.delete();
      m_busy = 0; m_mark = 0; m_err = 0; m_cur = 0;
    end else begin
      pop = (tst_rd || out_ready) && (mq.size() > 0);
      has = 0;
      w = 32'h0;
      if (tst_wr) begin has = 1; w = tst_wdata; end
      else if (m_busy && item_mask[m_cur]) begin has = 1; w = mk_word(m_cur); end
      if (ctrl_we && ctrl_wdata[3]) begin
        mq.delete();
        m_err = 0;
      end else begin
        if (pop) void'(mq.pop_front());
        if (has) begin
          if (mq.size() < DEPTH) mq.push_back(w);
          else m_err = 1;
        end
      end
      if (m_busy) begin
        if (!tst_wr) begin
          if (m_cur == NI-1) m_busy = 0;
          else m_cur++;
        end
      end else if (evt_valid && (m_mark || !(evt_veto || (|evt_pre)))) begin
        m_busy = 1; m_cur = 0;
        m_pat = evt_pattern; m_pre = evt_pre; m_post = evt_post; m_veto = evt_veto;
        m_she = evt_sh_e; m_sht = evt_sh_t;
        for (int c = 0; c < GE; c++) begin
          m_ehi[c] = evt_ehi[c*VW +: VW];
          m_elo[c] = evt_elo[c*VW +: VW];
          m_trig[c] = evt_ttrig[c*VW +: VW];
          m_xo[c] = evt_txo[c*VW +: VW];
        end
      end
      if (ctrl_we) m_mark = ctrl_wdata[1];
    end
  end

  // Per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && run_chk && !done) begin
      chk(out_valid == (mq.size() > 0), "R9", 32'(out_valid), 32'(mq.size() > 0), "out_valid");
      if (mq.size() > 0 && out_valid)
        chk(out_data == mq[0], tag_of(out_data, mq[0]), out_data, mq[0], "head word");
      chk(evt_ready == !m_busy, "R7", 32'(evt_ready), 32'(!m_busy), "evt_ready");
      chk(err_flag == m_err, "R10", 32'(err_flag), 32'(m_err), "err_flag");
    end
  end

  task automatic ctrl_write(logic [3:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0; ctrl_wdata = 4'h0;
  endtask

  task automatic send_evt(int seed, logic veto, logic [GE-1:0] pre, logic [GE-1:0] post);
    while (!evt_ready) @(negedge clk);
    evt_valid = 1;
    evt_pattern = 13'(seed*977 + 5);
    evt_veto = veto; evt_pre = pre; evt_post = post;
    evt_sh_e = 13'(seed*331 + 7);
    evt_sh_t = 13'(seed*57 + 8190);
    for (int c = 0; c < GE; c++) begin
      evt_ehi[c*VW +: VW] = 13'(seed*101 + c*13 + 1);
      evt_elo[c*VW +: VW] = 13'(seed*211 + c*29 + 8000);
      evt_ttrig[c*VW +: VW] = 13'(seed*17 + c*401 + 3);
      evt_txo[c*VW +: VW] = 13'(seed*613 + c*7 + 4095);
    end
    @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic drain();
    out_ready = 1;
    do @(negedge clk); while (out_valid || !evt_ready);
    out_ready = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ctrl_we = 0; ctrl_wdata = 0; grp_id = 8'h5A; item_mask = '1;
    evt_valid = 0; evt_pattern = 0; evt_ehi = 0; evt_elo = 0; evt_ttrig = 0; evt_txo = 0;
    evt_pre = 0; evt_post = 0; evt_veto = 0; evt_sh_e = 0; evt_sh_t = 0;
    tst_wr = 0; tst_wdata = 0; tst_rd = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R9", 32'(out_valid), 0, "reset empty");
    chk(evt_ready == 1, "R7", 32'(evt_ready), 1, "reset ready");
    chk(err_flag == 0, "R10", 32'(err_flag), 0, "reset flag");
    rst_n = 1; run_chk = 1;

    // Mark mode, all items, mixed flags (R4, R5, R6, R1)
    ctrl_write(4'h2);
    send_evt(1, 1'b1, 5'b00101, 5'b00110);
    drain();
    // Partial mask, consumer active while emitting (R7)
    item_mask = 23'h555555 & 23'h7FFFFF; grp_id = 8'hC3; out_ready = 1;
    send_evt(2, 1'b0, 5'b00000, 5'b10000);
    drain();
    item_mask = 23'h7E0E1; send_evt(3, 1'b0, 5'b11000, 5'b00011);
    drain();

    // Reject mode (R8)
    item_mask = '1;
    ctrl_write(4'h0);
    send_evt(4, 1'b1, 5'b00000, 5'b00000);
    chk(evt_ready == 1 && out_valid == 0, "R8", {evt_ready, out_valid}, 2'b10, "vetoed event dropped");
    send_evt(5, 1'b0, 5'b01000, 5'b00000);
    chk(evt_ready == 1 && out_valid == 0, "R8", {evt_ready, out_valid}, 2'b10, "pre-pileup event dropped");
    send_evt(6, 1'b0, 5'b00000, 5'b00001);
    @(negedge clk);
    chk(out_valid == 1, "R8", 32'(out_valid), 1, "post-pileup event kept");
    drain();

    // Test write and test read (R12)
    @(negedge clk); tst_wr = 1; tst_wdata = 32'hDEAD_0001;
    @(negedge clk); tst_wdata = 32'hBEEF_0002;
    @(negedge clk); tst_wr = 0;
    chk(out_data == 32'hDEAD_0001, "R12", out_data, 32'hDEAD_0001, "test word head");
    tst_rd = 1; @(negedge clk); tst_rd = 0;
    chk(out_data == 32'hBEEF_0002, "R12", out_data, 32'hBEEF_0002, "test read pop");
    drain();
    // Test write while busy stalls the sequence
    ctrl_write(4'h2);
    send_evt(7, 1'b1, 5'b10000, 5'b01000);
    repeat (4) @(negedge clk);
    tst_wr = 1; tst_wdata = 32'h1234_5678;
    repeat (2) @(negedge clk);
    tst_wr = 0;
    drain();

    // Overflow and clear (R10, R11)
    grp_id = 8'h0F;
    send_evt(8, 1'b0, 5'b0, 5'b0);
    send_evt(9, 1'b1, 5'b00010, 5'b0);
    send_evt(10, 1'b0, 5'b0, 5'b11111);
    while (!evt_ready) @(negedge clk);
    chk(err_flag == 1, "R10", 32'(err_flag), 1, "overflow flag set");
    repeat (3) @(negedge clk);
    chk(err_flag == 1, "R10", 32'(err_flag), 1, "overflow flag sticky");
    ctrl_write(4'hA);
    chk(out_valid == 0 && err_flag == 0, "R11", {out_valid, err_flag}, 0, "clear empties");
    send_evt(11, 1'b1, 5'b0, 5'b0);
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule